// File: doc/BRIEF.md
# Vector predicate mask fetch unit

This block produces the two element masks a vector instruction needs before it issues: one mask that qualifies source elements and one that qualifies destination elements. On a start pulse it latches a predicate mode, a source selector, a destination selector and the vector length. It then reads whatever register state the mode calls for, and raises a one-cycle done with both 64-bit masks valid.

Three mask sources exist. In integer mode each selector names one of a few general-purpose registers, optionally inverted, or asks for an all-ones mask or a one-hot "unary" mask. In condition-register mode the block walks consecutive 4-bit condition fields, one per element, and gathers one chosen condition bit from each. In the none mode both masks are simply all ones. The block owns one read port on the integer register file and one on the condition register file; both return data on the cycle after the request.

Top module: `vpred_mask_fetch`

## Requirements
- R1: Predicate mode 0 (none) and the spare mode 3 set both masks to all 64 ones regardless of vector length; done is seen one cycle after the start cycle.
- R2: Mode 1 (integer) decodes each selector on its own. Code 2 gives register 3, code 3 the complement of register 3, code 4 register 10, code 5 its complement, code 6 register 30 and code 7 its complement.
- R3: Integer code 0 yields all ones below the vector length, independent of any register contents.
- R4: Integer code 1 (unary) yields a single set bit at the position held in the low 6 bits of register 3. It yields zero if that position is at or above the vector length.
- R5: In integer mode, mask bits at or above the vector length are 0. A length above 64 acts as 64.
- R6: An integer fetch reads the source register first and the destination register on the next cycle, and asserts done 4 cycles after start.
- R7: Mode 2 (condition) decodes each selector as a bit index (code bits 2:1, where index 0 is LT, 1 GT, 2 EQ and 3 SO, i.e. bit k of the 4-bit field) plus an invert flag (code bit 0). Mask bit k equals the chosen bit of field FIRST_CRF+k, XOR the invert flag, for k below the vector length; higher bits are 0.
- R8: A condition fetch issues one field read per cycle over consecutive fields, starting at FIRST_CRF, once per element. Done comes vl+2 cycles after start; a length of 0 gives zero masks after 2 cycles.
- R9: done is a single-cycle pulse. busy is high from the cycle after start up to and including done. A start while busy is ignored.
- R10: After reset, busy, done and both read enables are low and both masks are zero. Only one read port is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fetch (taken only when idle) |
| pred_mode | input | 2 | 0 none, 1 integer, 2 condition, 3 treated as none |
| src_sel | input | 3 | Source predicate selector code |
| dst_sel | input | 3 | Destination predicate selector code |
| vec_len | input | 7 | Vector length, 0 to 127, clamped to 64 |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | One-cycle pulse: masks valid |
| src_mask | output | 64 | Source element mask |
| dst_mask | output | 64 | Destination element mask |
| int_rd_en | output | 1 | Integer register read request |
| int_rd_addr | output | 5 | Integer register number |
| int_rd_data | input | 64 | Integer read data, one cycle after request |
| cr_rd_en | output | 1 | Condition field read request |
| cr_rd_field | output | 7 | Condition field number |
| cr_rd_data | input | 4 | Condition field data, one cycle after request |

## Verification
The bench targets the unary position sitting exactly at and just above the vector length, where an off-by-one comparison would leave a stray bit or drop bit 63. It drives lengths of 0, 1, 64 and above 64. A bad clamp would truncate the mask or hang the condition loop, and a missed pipeline stage would shift gathered bits by one element or lose the last one. A start pulse in the middle of a condition fetch checks that the in-flight masks and latency are not disturbed. The order and count of register-file requests are recorded to catch a swapped source/destination read or a loop that reads one field too many.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

  localparam int GPR_AW = 5;

  typedef enum logic [1:0] {
    PM_NONE = 2'd0,
    PM_INT  = 2'd1,
    PM_CR   = 2'd2,
    PM_RSVD = 2'd3
  } pred_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INT_A = 3'd1,
    ST_INT_B = 3'd2,
    ST_INT_C = 3'd3,
    ST_CR    = 3'd4,
    ST_DONE  = 3'd5
  } fetch_st_e;

  typedef struct packed {
    logic [GPR_AW-1:0] reg_num;
    logic              inv;
    logic              unary;
    logic              ones;
  } int_sel_t;

  typedef struct packed {
    logic [1:0] bit_idx;
    logic       inv;
  } cr_sel_t;

  localparam logic [GPR_AW-1:0] GPR_ZERO = GPR_AW'(0);
  localparam logic [GPR_AW-1:0] GPR_A    = GPR_AW'(3);
  localparam logic [GPR_AW-1:0] GPR_B    = GPR_AW'(10);
  localparam logic [GPR_AW-1:0] GPR_C    = GPR_AW'(30);

endpackage

// File: rtl/vpm_int_dec.sv
module vpm_int_dec
  import vpm_pkg::*;
(
  input  logic [2:0] code,
  output int_sel_t   dec
);

  always_comb begin
    dec = '0;
    unique case (code)
      3'd0: begin dec.reg_num = GPR_ZERO; dec.inv = 1'b1; dec.ones = 1'b1; end
      3'd1: begin dec.reg_num = GPR_A; dec.unary = 1'b1; end
      3'd2: dec.reg_num = GPR_A;
      3'd3: begin dec.reg_num = GPR_A; dec.inv = 1'b1; end
      3'd4: dec.reg_num = GPR_B;
      3'd5: begin dec.reg_num = GPR_B; dec.inv = 1'b1; end
      3'd6: dec.reg_num = GPR_C;
      default: begin dec.reg_num = GPR_C; dec.inv = 1'b1; end
    endcase
  end

endmodule

// File: rtl/vpm_cr_dec.sv
module vpm_cr_dec
  import vpm_pkg::*;
(
  input  logic [2:0] code,
  output cr_sel_t    dec
);

  // bit index in code[2:1], polarity in code[0]
  always_comb begin
    dec.bit_idx = code[2:1];
    dec.inv     = code[0];
  end

endmodule

// File: rtl/vpm_len_mask.sv
module vpm_len_mask #(
  parameter int ELEMS = 64,
  localparam int VL_W = $clog2(ELEMS) + 1
) (
  input  logic [VL_W-1:0]  vl,
  output logic [ELEMS-1:0] lim
);

  for (genvar i = 0; i < ELEMS; i++) begin : g_lim
    assign lim[i] = (VL_W'(i) < vl);
  end

endmodule

// File: rtl/vpm_int_shape.sv
module vpm_int_shape
  import vpm_pkg::*;
#(
  parameter int ELEMS = 64,
  localparam int EIW = $clog2(ELEMS)
) (
  input  logic [ELEMS-1:0] rd_data,
  input  int_sel_t         dec,
  input  logic [ELEMS-1:0] lim,
  output logic [ELEMS-1:0] mask
);

  logic [ELEMS-1:0] one_hot;
  logic [ELEMS-1:0] raw;

  always_comb begin
    one_hot = '0;
    one_hot[rd_data[EIW-1:0]] = 1'b1;
  end

  always_comb begin
    if (dec.ones)       raw = '1;
    else if (dec.unary) raw = one_hot;
    else if (dec.inv)   raw = ~rd_data;
    else                raw = rd_data;
    mask = raw & lim;
  end

endmodule

// File: rtl/vpred_mask_fetch.sv
module vpred_mask_fetch
  import vpm_pkg::*;
#(
  parameter int ELEMS     = 64,
  parameter int CRF_AW    = 7,
  parameter int FIRST_CRF = 0,
  localparam int VL_W = $clog2(ELEMS) + 1,
  localparam int EIW  = $clog2(ELEMS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        pred_mode,
  input  logic [2:0]        src_sel,
  input  logic [2:0]        dst_sel,
  input  logic [VL_W-1:0]   vec_len,
  output logic              busy,
  output logic              done,
  output logic [ELEMS-1:0]  src_mask,
  output logic [ELEMS-1:0]  dst_mask,
  output logic              int_rd_en,
  output logic [GPR_AW-1:0] int_rd_addr,
  input  logic [ELEMS-1:0]  int_rd_data,
  output logic              cr_rd_en,
  output logic [CRF_AW-1:0] cr_rd_field,
  input  logic [3:0]        cr_rd_data
);

  fetch_st_e         st;
  pred_mode_e        mode_q;
  logic [2:0]        sel_q [2];
  logic [VL_W-1:0]   vl_q;
  logic [VL_W-1:0]   vl_clamped;
  logic [VL_W-1:0]   req_cnt;
  logic              pend;
  logic [EIW-1:0]    pend_idx;
  logic [ELEMS-1:0]  mask_q [2];
  logic [ELEMS-1:0]  lim;

  int_sel_t          int_dec [2];
  cr_sel_t           cr_dec  [2];
  logic [ELEMS-1:0]  shaped  [2];
  logic              cr_bit  [2];

  assign vl_clamped = (vec_len > VL_W'(ELEMS)) ? VL_W'(ELEMS) : vec_len;

  vpm_len_mask #(.ELEMS(ELEMS)) u_lim (.vl(vl_q), .lim(lim));

  // one decode and shaping path per mask slot: 0 source, 1 destination
  for (genvar g = 0; g < 2; g++) begin : g_slot
    vpm_int_dec u_idec (.code(sel_q[g]), .dec(int_dec[g]));
    vpm_cr_dec  u_cdec (.code(sel_q[g]), .dec(cr_dec[g]));
    vpm_int_shape #(.ELEMS(ELEMS)) u_shape (
      .rd_data (int_rd_data),
      .dec     (int_dec[g]),
      .lim     (lim),
      .mask    (shaped[g])
    );
    assign cr_bit[g] = cr_rd_data[cr_dec[g].bit_idx] ^ cr_dec[g].inv;
  end

  // read port requests derive from registered state only
  assign int_rd_en   = (st == ST_INT_A) || (st == ST_INT_B);
  assign int_rd_addr = (st == ST_INT_A) ? int_dec[0].reg_num : int_dec[1].reg_num;
  assign cr_rd_en    = (st == ST_CR) && (req_cnt < vl_q);
  assign cr_rd_field = CRF_AW'(FIRST_CRF) + CRF_AW'(req_cnt);

  assign busy     = (st != ST_IDLE);
  assign done     = (st == ST_DONE);
  assign src_mask = mask_q[0];
  assign dst_mask = mask_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      mode_q    <= PM_NONE;
      sel_q[0]  <= '0;
      sel_q[1]  <= '0;
      vl_q      <= '0;
      req_cnt   <= '0;
      pend      <= 1'b0;
      pend_idx  <= '0;
      mask_q[0] <= '0;
      mask_q[1] <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            mode_q   <= pred_mode_e'(pred_mode);
            sel_q[0] <= src_sel;
            sel_q[1] <= dst_sel;
            vl_q     <= vl_clamped;
            req_cnt  <= '0;
            pend     <= 1'b0;
            unique case (pred_mode_e'(pred_mode))
              PM_INT: st <= ST_INT_A;
              PM_CR: begin
                mask_q[0] <= '0;
                mask_q[1] <= '0;
                st        <= ST_CR;
              end
              default: begin
                mask_q[0] <= '1;
                mask_q[1] <= '1;
                st        <= ST_DONE;
              end
            endcase
          end
        end
        ST_INT_A: st <= ST_INT_B;
        ST_INT_B: begin
          mask_q[0] <= shaped[0];
          st        <= ST_INT_C;
        end
        ST_INT_C: begin
          mask_q[1] <= shaped[1];
          st        <= ST_DONE;
        end
        ST_CR: begin
          if (cr_rd_en) begin
            req_cnt  <= req_cnt + VL_W'(1);
            pend_idx <= req_cnt[EIW-1:0];
          end
          pend <= cr_rd_en;
          if (pend) begin
            mask_q[0][pend_idx] <= cr_bit[0];
            mask_q[1][pend_idx] <= cr_bit[1];
          end
          if (!cr_rd_en) st <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: done never lasts two cycles
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: start during a fetch leaves the latched request untouched
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(mode_q) && $stable(vl_q) && $stable(sel_q[0]) && $stable(sel_q[1])));

  // R10: the two read ports are never used together
  a_r10_one_port: assert property (@(posedge clk) disable iff (rst)
    !(int_rd_en && cr_rd_en));

  // R1: the none and spare modes finish with full masks
  a_r1_none_ones: assert property (@(posedge clk) disable iff (rst)
    (done && (mode_q == PM_NONE || mode_q == PM_RSVD)) |-> (&src_mask && &dst_mask));

  // R5: integer masks carry nothing at or above the length
  a_r5_int_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == PM_INT) |-> (((src_mask | dst_mask) & ~lim) == '0));

  // R7: condition masks carry nothing at or above the length
  a_r7_cr_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == PM_CR) |-> (((src_mask | dst_mask) & ~lim) == '0));

  // R2: the integer port only ever addresses the four decodable registers
  a_r2_int_addr: assert property (@(posedge clk) disable iff (rst)
    int_rd_en |-> (int_rd_addr == GPR_ZERO || int_rd_addr == GPR_A ||
                   int_rd_addr == GPR_B || int_rd_addr == GPR_C));

  // R8: back-to-back field reads walk consecutive fields
  a_r8_cr_consecutive: assert property (@(posedge clk) disable iff (rst)
    (cr_rd_en && $past(cr_rd_en)) |-> (cr_rd_field == $past(cr_rd_field) + CRF_AW'(1)));

endmodule

// File: tb/vpred_mask_fetch_tb_top.sv
module vpred_mask_fetch_tb_top;

  localparam int ELEMS     = 64;
  localparam int FIRST_CRF = 0;
  localparam int NV        = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  pred_mode = '0;
  logic [2:0]  src_sel = '0;
  logic [2:0]  dst_sel = '0;
  logic [6:0]  vec_len = '0;
  logic        busy, done;
  logic [63:0] src_mask, dst_mask;
  logic        int_rd_en;
  logic [4:0]  int_rd_addr;
  logic [63:0] int_rd_data = '0;
  logic        cr_rd_en;
  logic [6:0]  cr_rd_field;
  logic [3:0]  cr_rd_data = '0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [63:0] gpr [32];

  // 8 ns period: 125 MHz
  always #4 clk = ~clk;

  vpred_mask_fetch #(.ELEMS(ELEMS), .FIRST_CRF(FIRST_CRF)) dut_i (
    .clk(clk), .rst(rst), .start(start), .pred_mode(pred_mode),
    .src_sel(src_sel), .dst_sel(dst_sel), .vec_len(vec_len),
    .busy(busy), .done(done), .src_mask(src_mask), .dst_mask(dst_mask),
    .int_rd_en(int_rd_en), .int_rd_addr(int_rd_addr), .int_rd_data(int_rd_data),
    .cr_rd_en(cr_rd_en), .cr_rd_field(cr_rd_field), .cr_rd_data(cr_rd_data)
  );

  function automatic logic [3:0] cr_val(input int f);
    return 4'(((f * 5) + 3) ^ (f >> 2));
  endfunction

  // register file models with one cycle of read latency
  int n_int_req = 0;
  int int_log [4];
  int n_cr_req = 0;
  int last_cr  = -1;
  always @(posedge clk) begin
    if (int_rd_en) begin
      int_rd_data <= gpr[int_rd_addr];
      if (n_int_req < 4) int_log[n_int_req] <= int'(int_rd_addr);
      n_int_req <= n_int_req + 1;
    end
    if (cr_rd_en) begin
      cr_rd_data <= cr_val(int'(cr_rd_field));
      n_cr_req   <= n_cr_req + 1;
      last_cr    <= int'(cr_rd_field);
    end
  end

  function automatic logic [63:0] lim_of(input int vl);
    logic [63:0] m = '0;
    for (int i = 0; i < 64; i++) if (i < vl) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [63:0] exp_int(input logic [2:0] code, input int vl);
    logic [63:0] m;
    case (code)
      3'd0: m = '1;
      3'd1: begin m = '0; m[gpr[3][5:0]] = 1'b1; end
      3'd2: m = gpr[3];
      3'd3: m = ~gpr[3];
      3'd4: m = gpr[10];
      3'd5: m = ~gpr[10];
      3'd6: m = gpr[30];
      default: m = ~gpr[30];
    endcase
    return m & lim_of(vl);
  endfunction

  function automatic logic [63:0] exp_cr(input logic [2:0] code, input int vl);
    logic [63:0] m = '0;
    for (int k = 0; k < 64; k++)
      if (k < vl) m[k] = cr_val(FIRST_CRF + k)[code[2:1]] ^ code[0];
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_fetch(input logic [1:0] m, input logic [2:0] s, input logic [2:0] d,
                           input int vl, output int lat);
    @(negedge clk);
    n_int_req = 0;
    n_cr_req  = 0;
    last_cr   = -1;
    pred_mode = m; src_sel = s; dst_sel = d; vec_len = 7'(vl);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // stimulus and expected latency: {mode, src code, dst code, vl, latency}
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 3'd0, 3'd0, 8'd5,   8'd1},
    {2'd1, 3'd2, 3'd3, 8'd64,  8'd4},
    {2'd1, 3'd4, 3'd5, 8'd64,  8'd4},
    {2'd1, 3'd6, 3'd7, 8'd33,  8'd4},
    {2'd1, 3'd0, 3'd1, 8'd64,  8'd4},
    {2'd1, 3'd1, 3'd0, 8'd16,  8'd4},
    {2'd2, 3'd0, 3'd1, 8'd8,   8'd10},
    {2'd2, 3'd2, 3'd3, 8'd64,  8'd66},
    {2'd2, 3'd4, 3'd5, 8'd1,   8'd3},
    {2'd2, 3'd6, 3'd7, 8'd37,  8'd39},
    {2'd3, 3'd2, 3'd4, 8'd7,   8'd1},
    {2'd1, 3'd3, 3'd2, 8'd100, 8'd4},
    {2'd2, 3'd0, 3'd7, 8'd0,   8'd2},
    {2'd2, 3'd5, 3'd2, 8'd100, 8'd66}
  };

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    for (int i = 0; i < 32; i++) gpr[i] = {32'(i * 32'h9E37_79B9), 32'(i * 32'h0101_0101 + 5)};
    gpr[0]  = 64'h5A5A_1234_0000_FFFF;
    gpr[3]  = 64'hA5C3_0F0F_1234_5625;
    gpr[10] = 64'h0123_4567_89AB_CDEF;
    gpr[30] = 64'hFFFF_0000_F0F0_3C3C;

    repeat (3) @(negedge clk);
    // R10: reset state
    check(busy == 1'b0 && done == 1'b0, "R10 reset busy/done", {62'd0, busy, done}, 64'd0);
    check(src_mask == '0 && dst_mask == '0, "R10 reset masks", src_mask | dst_mask, 64'd0);
    check(!int_rd_en && !cr_rd_en, "R10 reset read enables", {62'd0, int_rd_en, cr_rd_en}, 64'd0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      logic [1:0] m;
      logic [2:0] s, d;
      int vl, el, ev;
      logic [63:0] es, ed;
      m  = VEC[v][23:22];
      s  = VEC[v][21:19];
      d  = VEC[v][18:16];
      vl = int'(VEC[v][15:8]);
      el = int'(VEC[v][7:0]);
      ev = (vl > 64) ? 64 : vl;
      if (m == 2'd1)      begin es = exp_int(s, ev); ed = exp_int(d, ev); end
      else if (m == 2'd2) begin es = exp_cr(s, ev);  ed = exp_cr(d, ev);  end
      else                begin es = '1;             ed = '1;             end
      run_fetch(m, s, d, vl, lat);
      // R1 R2 R3 R4 R5 R7: mask contents per mode
      check(src_mask == es, $sformatf("R1/R2/R3/R4/R5/R7 src vec%0d", v), src_mask, es);
      check(dst_mask == ed, $sformatf("R1/R2/R3/R4/R5/R7 dst vec%0d", v), dst_mask, ed);
      // R6 R8: latency
      check(lat == el, $sformatf("R6/R8 latency vec%0d", v), 64'(lat), 64'(el));
      if (m == 2'd2)
        check(n_cr_req == ev && (ev == 0 || last_cr == FIRST_CRF + ev - 1),
              $sformatf("R8 field reads vec%0d", v), 64'(n_cr_req), 64'(ev));
    end

    // R6: source register requested before destination
    run_fetch(2'd1, 3'd4, 3'd6, 64, lat);
    check(n_int_req == 2 && int_log[0] == 10 && int_log[1] == 30, "R6 read order",
          64'(int_log[0] * 100 + int_log[1]), 64'(10 * 100 + 30));
    // R9: done pulse is one cycle wide
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R9 done single pulse", {62'd0, busy, done}, 64'd0);

    // R4: unary position at the top bit, inside and outside the length
    gpr[3] = 64'h0000_0000_0000_003F;
    run_fetch(2'd1, 3'd1, 3'd1, 64, lat);
    check(src_mask == 64'h8000_0000_0000_0000, "R4 unary bit 63 vl 64", src_mask, 64'h8000_0000_0000_0000);
    run_fetch(2'd1, 3'd1, 3'd2, 63, lat);
    check(src_mask == '0, "R4 unary at vl edge", src_mask, 64'd0);
    check(dst_mask == 64'h3F, "R2 plain reg3 vl 63", dst_mask, 64'h3F);

    // R9: a start during a condition fetch is ignored
    @(negedge clk);
    n_cr_req = 0;
    pred_mode = 2'd2; src_sel = 3'd4; dst_sel = 3'd1; vec_len = 7'd10;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(busy == 1'b1, "R9 busy during fetch", {63'd0, busy}, 64'd1);
    pred_mode = 2'd0; vec_len = 7'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 3;
    while (!done && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 12, "R9 ignored start keeps latency", 64'(lat), 64'd12);
    check(src_mask == exp_cr(3'd4, 10), "R9 ignored start src", src_mask, exp_cr(3'd4, 10));
    check(dst_mask == exp_cr(3'd1, 10), "R9 ignored start dst", dst_mask, exp_cr(3'd1, 10));
    @(negedge clk);
    check(busy == 1'b0, "R9 idle after ignored start", {63'd0, busy}, 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule